// File: doc/BRIEF.md
# Pin-Change Interrupt Unit

This unit watches an input port of `WIDTH` pins and flags level changes on them. Each pin's input passes through its own synchroniser. Each pin also has two separately enabled edge detectors: one for rising transitions and one for falling transitions. A detected edge sets a sticky per-pin flag. The flags are OR-reduced into a summary bit. That summary bit, gated by a master enable, forms a level interrupt request toward the processor core. While the device is asleep, the same condition raises a wake request for the sleep controller.

Software reaches the unit through a small synchronous write port with four addresses. Two addresses hold the rising and falling enable masks. One holds the flags. One holds the master enable.

Writes to the flag address only ever clear bits, because the new value is the AND of the old value and the written data. An edge detected in the same cycle as a flag write always leaves that flag set. A clear sequence therefore cannot lose an event.

Top module: `pin_change_irq`

## Requirements
- R1: While reset is low and in the first cycle after it, the flags, both enable masks, the master enable, the summary flag, the interrupt request and the wake request are all 0.
- R2: A pin whose rising-enable bit (address 0) is 1 sets its flag after a 0-to-1 transition. The flag becomes visible `SYNC_STAGES` clock edges after the first edge that samples the new level.
- R3: A pin whose falling-enable bit (address 1) is 1 sets its flag after a 1-to-0 transition, with the same latency as R2.
- R4: With both enable bits set, a pin flags transitions in either direction. With neither bit set, the pin never sets its flag.
- R5: A set flag stays 1 until a write to the flag address (address 2) clears it. Pin activity and changes to the enables do not clear it.
- R6: `anyFlag` is 1 exactly when at least one flag bit is 1.
- R7: `irqReq` equals the master enable (address 3, bit 0) AND `anyFlag`. Flags are still set while the master enable is 0.
- R8: A write to address 2 makes each flag bit the old bit AND the written bit, OR any edge detected in that cycle.
- R9: If an enabled edge is detected in the cycle of a flag write, that pin's flag is 1 afterwards, whatever value was written to it.
- R10: Clearing an enable bit stops new flags of that edge type but leaves an already set flag at 1.
- R11: `wakeReq` is 1 when `sleepMode`, the master enable and `anyFlag` are all 1, and 0 otherwise. The flag is set no later than the cycle in which `wakeReq` rises.
- R12: A pin that is held at a constant level through reset and after it produces no flag, even when both enables are written to all ones right after reset.
- R13: The enable masks and the master enable read back on `riseEnOut`, `fallEnOut` and `masterEnOut` one cycle after they are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | WIDTH | Asynchronous port pins |
| sleepMode | input | 1 | Device is asleep |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | 0 rising enables, 1 falling enables, 2 flags, 3 master enable |
| wrData | input | WIDTH | Write data |
| riseEnOut | output | WIDTH | Rising-edge enable mask |
| fallEnOut | output | WIDTH | Falling-edge enable mask |
| masterEnOut | output | 1 | Master interrupt enable |
| flags | output | WIDTH | Sticky per-pin flags |
| anyFlag | output | 1 | OR of all flags |
| irqReq | output | 1 | Level interrupt request |
| wakeReq | output | 1 | Wake request to the sleep controller |

## Verification
The case that is hardest to reach from the ports is a flag write that lands in exactly the cycle in which an edge sits in the synchroniser output. The stimulus changes a pin at a known negative edge. It then counts the synchroniser stages and presents a write of zeros so that it is sampled on the same rising edge that stores the detected edge. Another flag that was set earlier must clear, and the racing flag must survive. A separate sequence holds the pins high through reset and enables both edge types at once. This shows that a chain which starts from a wrong value would report a phantom edge.

// File: rtl/pin_change_pkg.sv
package pin_change_pkg;
  localparam logic [1:0] ADDR_RISE   = 2'd0;
  localparam logic [1:0] ADDR_FALL   = 2'd1;
  localparam logic [1:0] ADDR_FLAG   = 2'd2;
  localparam logic [1:0] ADDR_MASTER = 2'd3;

  typedef struct packed {
    logic riseWr;
    logic fallWr;
    logic flagWr;
    logic masterWr;
  } pinChgStrobe_t;
endpackage

// File: rtl/pin_change_ctrl.sv
module pin_change_ctrl
  import pin_change_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic             sleepMode,
  input  logic             anyFlag,
  output pinChgStrobe_t    strobe,
  output logic [WIDTH-1:0] riseEnQ,
  output logic [WIDTH-1:0] fallEnQ,
  output logic             masterEnQ,
  output logic             irqReq,
  output logic             wakeReq
);
  always_comb begin
    strobe          = '0;
    strobe.riseWr   = wrEn && (wrAddr == ADDR_RISE);
    strobe.fallWr   = wrEn && (wrAddr == ADDR_FALL);
    strobe.flagWr   = wrEn && (wrAddr == ADDR_FLAG);
    strobe.masterWr = wrEn && (wrAddr == ADDR_MASTER);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      riseEnQ   <= '0;
      fallEnQ   <= '0;
      masterEnQ <= 1'b0;
    end else begin
      if (strobe.riseWr)   riseEnQ   <= wrData;
      if (strobe.fallWr)   fallEnQ   <= wrData;
      if (strobe.masterWr) masterEnQ <= wrData[0];
    end
  end

  always_comb begin
    irqReq  = masterEnQ & anyFlag;
    wakeReq = irqReq & sleepMode;
  end
endmodule

// File: rtl/pin_change_datapath.sv
module pin_change_datapath
  import pin_change_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  input  pinChgStrobe_t    strobe,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] riseEn,
  input  logic [WIDTH-1:0] fallEn,
  output logic [WIDTH-1:0] flagQ,
  output logic             anyFlag
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [WIDTH-1:0] syncChain [SYNC_STAGES];
  logic [WIDTH-1:0] pinSync;
  logic [WIDTH-1:0] prevQ;
  logic [WIDTH-1:0] edgeHit;
  logic [WIDTH-1:0] keepMask;

  // Synchroniser runs through reset so the chain holds the true pin level at release
  always_ff @(posedge clk) syncChain[0] <= pinIn;

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) syncChain[s] <= syncChain[s-1];
    end
  endgenerate

  assign pinSync = syncChain[LAST];

  // Previous sample follows the synchronised level, also during reset
  always_ff @(posedge clk) prevQ <= pinSync;

  generate
    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
      logic riseHit;
      logic fallHit;
      assign riseHit    = riseEn[p] &  pinSync[p] & ~prevQ[p];
      assign fallHit    = fallEn[p] & ~pinSync[p] &  prevQ[p];
      assign edgeHit[p] = riseHit | fallHit;
    end
  endgenerate

  assign keepMask = strobe.flagWr ? wrData : '1;

  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= (flagQ & keepMask) | edgeHit;
  end

  assign anyFlag = |flagQ;
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pin_change_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  input  logic             sleepMode,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] riseEnOut,
  output logic [WIDTH-1:0] fallEnOut,
  output logic             masterEnOut,
  output logic [WIDTH-1:0] flags,
  output logic             anyFlag,
  output logic             irqReq,
  output logic             wakeReq
);
  pinChgStrobe_t strobe;

  pin_change_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sleepMode(sleepMode), .anyFlag(anyFlag), .strobe(strobe),
    .riseEnQ(riseEnOut), .fallEnQ(fallEnOut), .masterEnQ(masterEnOut),
    .irqReq(irqReq), .wakeReq(wakeReq)
  );

  pin_change_datapath #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .strobe(strobe), .wrData(wrData),
    .riseEn(riseEnOut), .fallEn(fallEnOut), .flagQ(flags), .anyFlag(anyFlag)
  );
endmodule

// File: rtl/pin_change_checker.sv
module pin_change_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       wrAddr,
  input logic             sleepMode,
  input logic             masterEnOut,
  input logic [WIDTH-1:0] flags,
  input logic             anyFlag,
  input logic             irqReq,
  input logic             wakeReq
);
  // R1
  reset_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (flags == '0) && !irqReq && !wakeReq && !masterEnOut);

  // R5
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == 2'd2) |=> ((flags & $past(flags)) == $past(flags)));

  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> anyFlag && (flags != '0));

  // R7
  irq_master_chk: assert property (@(posedge clk) disable iff (!rstN)
    !masterEnOut |-> !irqReq);

  // R11
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> irqReq && sleepMode && (flags != '0));
endmodule

bind pin_change_irq pin_change_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .sleepMode(sleepMode),
  .masterEnOut(masterEnOut), .flags(flags), .anyFlag(anyFlag),
  .irqReq(irqReq), .wakeReq(wakeReq)
);

// File: tb/pin_change_irq_bench.sv
module pin_change_irq_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] pinIn = '0;
  logic         sleepMode = 1'b0;
  logic         wrEn = 1'b0;
  logic [1:0]   wrAddr = '0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] riseEnOut, fallEnOut, flags;
  logic         masterEnOut, anyFlag, irqReq, wakeReq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #5 clk = ~clk;

  pin_change_irq #(.WIDTH(W), .SYNC_STAGES(2)) u_pin_change_irq (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .sleepMode(sleepMode),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .riseEnOut(riseEnOut), .fallEnOut(fallEnOut), .masterEnOut(masterEnOut),
    .flags(flags), .anyFlag(anyFlag), .irqReq(irqReq), .wakeReq(wakeReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg;
  endfunction

  task automatic regWrite(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    idle(4);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] rise, fall, oldP, newP, expFlags, pre;
    logic m, s;

    idle(3);
    // R1: state while in reset
    check("R1 flags in reset", flags, 0);
    check("R1 irq in reset", irqReq, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 enables after reset", {riseEnOut, fallEnOut, masterEnOut}, 0);
    check("R1 wake after reset", wakeReq, 0);

    // R13 readback
    regWrite(2'd0, 8'hA5);
    check("R13 rise mask", riseEnOut, 8'hA5);
    regWrite(2'd1, 8'h3C);
    check("R13 fall mask", fallEnOut, 8'h3C);
    regWrite(2'd3, 8'h01);
    check("R13 master", masterEnOut, 1);

    // R2 R3 R4 R6 R7 R11: random sweep over masks and pin transitions
    for (int it = 0; it < 96; it++) begin
      rise = nextRand() >> 8; fall = nextRand() >> 8;
      oldP = nextRand() >> 8; newP = nextRand() >> 8;
      m = nextRand() >> 20; s = nextRand() >> 20;
      if (it < 4) begin rise = (it[0]) ? 8'hFF : 8'h00; fall = (it[1]) ? 8'hFF : 8'h00; end
      pinIn = oldP;
      regWrite(2'd0, rise);
      regWrite(2'd1, fall);
      regWrite(2'd3, {7'd0, m});
      sleepMode = s;
      idle(4);
      regWrite(2'd2, 8'h00);
      check("R8 cleared", flags, 0);
      pinIn = newP;
      // one edge samples, one more stage, then the flag register
      idle(2);
      check("R2 R3 not early", flags, 0);
      @(negedge clk);
      expFlags = (rise & newP & ~oldP) | (fall & ~newP & oldP);
      check("R2 R3 R4 flags", flags, expFlags);
      check("R6 anyFlag", anyFlag, expFlags != 0);
      check("R7 irqReq", irqReq, m & (expFlags != 0));
      check("R11 wakeReq", wakeReq, s & m & (expFlags != 0));
    end
    sleepMode = 1'b0;

    // R5 and R10: sticky through pin return and enable clear
    pinIn = 8'h00;
    regWrite(2'd0, 8'hFF); regWrite(2'd1, 8'h00);
    idle(4); regWrite(2'd2, 8'h00);
    pinIn = 8'h0F; idle(4);
    check("R2 setup", flags, 8'h0F);
    regWrite(2'd0, 8'h00);
    pinIn = 8'h00; idle(4);
    check("R5 R10 sticky", flags, 8'h0F);
    pinIn = 8'hF0; idle(4);
    check("R10 no new flags", flags, 8'h0F);

    // R8 write-AND
    regWrite(2'd2, 8'h05);
    check("R8 and-mask", flags, 8'h05);
    regWrite(2'd2, 8'hFF);
    check("R8 ones keep", flags, 8'h05);

    // R9 race: edge stored on the same edge as a zero write
    pinIn = 8'h00;
    regWrite(2'd0, 8'h01);
    idle(4);
    @(negedge clk); pinIn = 8'h01;      // sampled at edge k
    @(negedge clk);                      // after k
    wrEn = 1'b1; wrAddr = 2'd2; wrData = 8'h00; // sampled at k+2 with edge
    @(negedge clk);                      // after k+1
    @(negedge clk);                      // after k+2
    wrEn = 1'b0;
    check("R9 race flag", flags, 8'h01);

    // R7: flags still set with master off
    regWrite(2'd3, 8'h00);
    regWrite(2'd2, 8'h00);
    pinIn = 8'h00; regWrite(2'd1, 8'h01); idle(4);
    check("R7 flag without master", flags, 8'h01);
    check("R7 irq off", irqReq, 0);
    sleepMode = 1'b1;
    @(negedge clk);
    check("R11 no wake without master", wakeReq, 0);
    regWrite(2'd3, 8'h01);
    check("R11 wake", wakeReq, 1);
    sleepMode = 1'b0;

    // R12: pins high through reset, all enables set at once
    pinIn = 8'hFF;
    doReset();
    wrEn = 1'b1; wrAddr = 2'd0; wrData = 8'hFF;
    @(negedge clk);
    wrAddr = 2'd1;
    @(negedge clk);
    wrEn = 1'b0;
    idle(5);
    check("R12 no phantom edge", flags, 0);
    pinIn = 8'h7F; idle(4);
    check("R3 after reset", flags, 8'h80);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule